// File: doc/BRIEF.md
# PWM Generator with Emergency Shutdown

This block produces a bank of pulse-width-modulated outputs from 8-bit channels. Neighbouring channels can be joined in pairs to form one 16-bit channel. Each channel has a counter that runs from zero up to its period minus one. The output is active while the count is below the duty value, and a per-channel polarity bit sets which level counts as active.

The pin of the highest channel can be turned into an emergency shutdown input. While that input is high, every other output is forced to one programmed safe level, and a sticky shutdown flag is raised. When the input drops again, the outputs do not return to normal straight away. Each channel, or each joined pair, keeps the safe level until its own counter wraps back to zero, and only if the restart-enable bit is set. A low-power hold input freezes all counters. A frozen counter cannot wrap, so an output that is holding the safe level cannot be released while the hold is active.

All inputs are synchronous to the clock.

Top module: `pwm_estop`

## Requirements
- R1: An enabled 8-bit channel with period P greater than 0 counts 0, 1, ... P-1 and then wraps to 0, one step per clock. With polarity bit 1 its pin is 1 exactly while count < duty, so a duty of P or more keeps the pin at 1.
- R2: With polarity bit 0 the pin of an enabled channel is the inverse of the R1 waveform.
- R3: A disabled channel holds its counter at 0 and drives its pin to 0 whatever its polarity. After reset all pins and the shutdown flag are 0.
- R4: Setting bit p of `pair_cat` joins channels 2p (low byte) and 2p+1 (high byte) into one 16-bit counter. The joined counter uses the combined period and duty and the enable and polarity of channel 2p+1, and drives pin 2p+1. Pin 2p is 0 unless it is forced to the safe level.
- R5: While `sd_enable` is 1, pin NUM_CH-1 is 0. While `sd_enable` is 0, `sd_pin` has no effect on any pin or on the flag.
- R6: In any cycle where `sd_enable` and `sd_pin` are both 1, pins 0 to NUM_CH-2 equal `safe_lvl` in that same cycle.
- R7: `sd_flag` becomes 1 in the cycle after the shutdown input (`sd_enable` and `sd_pin`) rises. It stays 1 until a cycle with `flag_clr` high. If a rise and a clear fall in the same cycle, the rise wins.
- R8: After the shutdown input falls, each pin stays at `safe_lvl` until its counter wraps to zero while `restart_en` is 1. The first cycle at count zero already shows the normal waveform.
- R9: While `restart_en` is 0, a pin held at the safe level stays there, even across counter wraps.
- R10: For a joined pair, the hold ends only when the full 16-bit count wraps. A low byte of zero with a nonzero high byte does not release it.
- R11: While `lp_hold` is 1, all counters keep their value and no held pin is released. Counting resumes from the frozen value when `lp_hold` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sd_enable | input | 1 | Use the top channel pin as the shutdown input |
| sd_pin | input | 1 | Shutdown input level, active high |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_pol | input | NUM_CH | Per-channel polarity, 1 = active high |
| period_flat | input | NUM_CH*CW | Per-channel period, channel i at bits [i*CW +: CW] |
| duty_flat | input | NUM_CH*CW | Per-channel duty, same layout |
| pair_cat | input | NUM_CH/2 | Per-pair 16-bit join select |
| safe_lvl | input | 1 | Level forced during and after shutdown |
| restart_en | input | 1 | Allow release at counter wrap |
| lp_hold | input | 1 | Low-power hold, freezes counters |
| flag_clr | input | 1 | Clear strobe for the shutdown flag |
| pwm_out | output | NUM_CH | Channel pins |
| sd_flag | output | 1 | Sticky shutdown flag |

## Verification
The hardest situation to reach from the ports is a joined pair whose shutdown ends while the 16-bit count is still far from its wrap, with the count later passing through a value whose low byte is zero. A design that watched only one byte would release the pin at that point. The bench reaches this case by counting clock cycles from the moment it enables the pair. It drops the shutdown input at a known count and samples the pin at count 256 of a 384-cycle period. In the same way, it raises the low-power hold one cycle before an 8-bit wrap is due and keeps it high well past that point.

// File: rtl/pwm_estop_pkg.sv
package pwm_estop_pkg;

    typedef enum logic {
        PAIR_SPLIT = 1'b0,
        PAIR_CAT   = 1'b1
    } pair_mode_e;

    // Apply the channel polarity to the "count below duty" condition.
    function automatic logic apply_pol(input logic below, input logic pol);
        return pol ? below : ~below;
    endfunction

endpackage

// File: rtl/pwm_estop_pair.sv
module pwm_estop_pair
    import pwm_estop_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pair_mode_e    mode,
    input  logic [1:0]    en,
    input  logic [1:0]    pol,
    input  logic [CW-1:0] per_lo,
    input  logic [CW-1:0] per_hi,
    input  logic [CW-1:0] duty_lo,
    input  logic [CW-1:0] duty_hi,
    input  logic          freeze,
    output logic [1:0]    wave,
    output logic [1:0]    wrap
);
    localparam int WW = 2 * CW;

    typedef struct packed {
        logic [CW-1:0] hi;
        logic [CW-1:0] lo;
    } cnt_t;

    cnt_t st_d, st_q;

    logic [WW-1:0] cat_cnt, cat_per, cat_duty;
    logic          cat_end, lo_end, hi_end;

    always_comb begin
        st_d     = st_q;
        wave     = '0;
        wrap     = '0;
        cat_cnt  = st_q;
        cat_per  = {per_hi, per_lo};
        cat_duty = {duty_hi, duty_lo};
        cat_end  = (cat_per != '0) && (cat_cnt >= cat_per - WW'(1));
        lo_end   = (per_lo != '0) && (st_q.lo >= per_lo - CW'(1));
        hi_end   = (per_hi != '0) && (st_q.hi >= per_hi - CW'(1));

        if (mode == PAIR_CAT) begin
            // one 16-bit counter, driven out on the odd pin
            if (!en[1]) begin
                st_d = '0;
            end else if (!freeze && cat_per != '0) begin
                wrap = {2{cat_end}};
                st_d = cat_end ? '0 : cat_cnt + WW'(1);
            end
            wave[1] = en[1] & apply_pol(cat_cnt < cat_duty, pol[1]);
        end else begin
            // two independent 8-bit lanes
            if (!en[0]) begin
                st_d.lo = '0;
            end else if (!freeze && per_lo != '0) begin
                wrap[0] = lo_end;
                st_d.lo = lo_end ? '0 : st_q.lo + CW'(1);
            end
            if (!en[1]) begin
                st_d.hi = '0;
            end else if (!freeze && per_hi != '0) begin
                wrap[1] = hi_end;
                st_d.hi = hi_end ? '0 : st_q.hi + CW'(1);
            end
            wave[0] = en[0] & apply_pol(st_q.lo < duty_lo, pol[0]);
            wave[1] = en[1] & apply_pol(st_q.hi < duty_hi, pol[1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwm_estop_guard.sv
module pwm_estop_guard #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_in,
    input  logic              restart_en,
    input  logic              flag_clr,
    input  logic [NUM_CH-1:0] wrap,
    output logic [NUM_CH-1:0] hold_vec,
    output logic              flag
);
    typedef struct packed {
        logic [NUM_CH-1:0] hold;
        logic              sd_seen;
        logic              flag;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d         = g_q;
        g_d.sd_seen = sd_in;

        // hold sets while shutdown is active; each bit clears at its own wrap
        if (sd_in)           g_d.hold = '1;
        else if (restart_en) g_d.hold = g_q.hold & ~wrap;

        // a new rising edge has priority over the clear strobe
        if (sd_in && !g_q.sd_seen) g_d.flag = 1'b1;
        else if (flag_clr)         g_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign hold_vec = g_q.hold;
    assign flag     = g_q.flag;

endmodule

// File: rtl/pwm_estop.sv
module pwm_estop
    import pwm_estop_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sd_enable,
    input  logic                 sd_pin,
    input  logic [NUM_CH-1:0]    ch_en,
    input  logic [NUM_CH-1:0]    ch_pol,
    input  logic [NUM_CH*CW-1:0] period_flat,
    input  logic [NUM_CH*CW-1:0] duty_flat,
    input  logic [NUM_CH/2-1:0]  pair_cat,
    input  logic                 safe_lvl,
    input  logic                 restart_en,
    input  logic                 lp_hold,
    input  logic                 flag_clr,
    output logic [NUM_CH-1:0]    pwm_out,
    output logic                 sd_flag
);
    localparam int NPAIR = NUM_CH / 2;

    logic              sd_in;
    logic [NUM_CH-1:0] wave_vec, wrap_vec, hold_vec, pin_d;

    assign sd_in = sd_enable & sd_pin;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pwm_estop_pair #(.CW(CW)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (pair_mode_e'(pair_cat[p])),
            .en      (ch_en[2*p +: 2]),
            .pol     (ch_pol[2*p +: 2]),
            .per_lo  (period_flat[(2*p)*CW +: CW]),
            .per_hi  (period_flat[(2*p+1)*CW +: CW]),
            .duty_lo (duty_flat[(2*p)*CW +: CW]),
            .duty_hi (duty_flat[(2*p+1)*CW +: CW]),
            .freeze  (lp_hold),
            .wave    (wave_vec[2*p +: 2]),
            .wrap    (wrap_vec[2*p +: 2])
        );
    end

    pwm_estop_guard #(.NUM_CH(NUM_CH)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .sd_in      (sd_in),
        .restart_en (restart_en),
        .flag_clr   (flag_clr),
        .wrap       (wrap_vec),
        .hold_vec   (hold_vec),
        .flag       (sd_flag)
    );

    // Forcing follows the live shutdown input, so the safe level appears without a cycle of delay.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            pin_d[i] = (sd_in || hold_vec[i]) ? safe_lvl : wave_vec[i];
        end
        if (sd_enable) pin_d[NUM_CH-1] = 1'b0;
    end

    assign pwm_out = pin_d;

endmodule

// File: rtl/pwm_estop_chk.sv
module pwm_estop_chk #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_enable,
    input logic              sd_pin,
    input logic              safe_lvl,
    input logic              restart_en,
    input logic              lp_hold,
    input logic              flag_clr,
    input logic [NUM_CH-1:0] pwm_out,
    input logic              sd_flag,
    input logic [NUM_CH-1:0] hold_vec
);

    assert_top_pin_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sd_enable |-> (pwm_out[NUM_CH-1] == 1'b0));

    assert_safe_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_enable && sd_pin) |-> (pwm_out[NUM_CH-2:0] == {(NUM_CH-1){safe_lvl}}));

    assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_enable && sd_pin && !$past(sd_enable && sd_pin)) |=> sd_flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_flag && !flag_clr) |=> sd_flag);

    assert_no_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_en |=> (($past(hold_vec) & ~hold_vec) == '0));

    assert_lp_keeps_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lp_hold |=> (($past(hold_vec) & ~hold_vec) == '0));

endmodule

bind pwm_estop pwm_estop_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sd_enable  (sd_enable),
    .sd_pin     (sd_pin),
    .safe_lvl   (safe_lvl),
    .restart_en (restart_en),
    .lp_hold    (lp_hold),
    .flag_clr   (flag_clr),
    .pwm_out    (pwm_out),
    .sd_flag    (sd_flag),
    .hold_vec   (hold_vec)
);

// File: tb/tb_pwm_estop.sv
`timescale 1ns/100ps
module tb_pwm_estop;
    localparam int NUM_CH = 8;
    localparam int CW     = 8;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 sd_enable, sd_pin;
    logic [NUM_CH-1:0]    ch_en, ch_pol;
    logic [NUM_CH*CW-1:0] period_flat, duty_flat;
    logic [NUM_CH/2-1:0]  pair_cat;
    logic                 safe_lvl, restart_en, lp_hold, flag_clr;
    logic [NUM_CH-1:0]    pwm_out;
    logic                 sd_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_estop #(.NUM_CH(NUM_CH), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .sd_enable(sd_enable), .sd_pin(sd_pin),
        .ch_en(ch_en), .ch_pol(ch_pol), .period_flat(period_flat),
        .duty_flat(duty_flat), .pair_cat(pair_cat), .safe_lvl(safe_lvl),
        .restart_en(restart_en), .lp_hold(lp_hold), .flag_clr(flag_clr),
        .pwm_out(pwm_out), .sd_flag(sd_flag)
    );

    // one clock step; the bench drives and samples 1 ns or more after the edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic adv(input int n);
        repeat (n) tick();
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_ch(input int idx, input int per, input int duty,
                          input logic pol, input logic en);
        period_flat[idx*CW +: CW] = CW'(per);
        duty_flat[idx*CW +: CW]   = CW'(duty);
        ch_pol[idx] = pol;
        ch_en[idx]  = en;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sd_enable = 1'b0; sd_pin = 1'b0; ch_en = '0; ch_pol = '0;
        period_flat = '0; duty_flat = '0; pair_cat = '0; safe_lvl = 1'b0;
        restart_en = 1'b1; lp_hold = 1'b0; flag_clr = 1'b0;
        adv(2);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        #0.5;
        check(pwm_out, 0, "R3 pins after reset");
        check(sd_flag, 0, "R3 flag after reset");
    endtask

    task automatic t_basic();
        do_reset();
        set_ch(0, 4, 1, 1'b1, 1'b1);
        set_ch(1, 4, 1, 1'b0, 1'b1);
        set_ch(2, 4, 1, 1'b0, 1'b0);
        set_ch(3, 4, 9, 1'b1, 1'b1);
        #0.5;
        for (int k = 0; k < 8; k++) begin
            check(pwm_out[0], ((k % 4) < 1) ? 1 : 0, "R1 active-high waveform");
            check(pwm_out[1], ((k % 4) < 1) ? 0 : 1, "R2 inverted waveform");
            check(pwm_out[2], 0, "R3 disabled channel low");
            check(pwm_out[3], 1, "R1 duty above period stays high");
            tick();
        end
    endtask

    task automatic t_cat();
        int highs;
        do_reset();
        pair_cat[0] = 1'b1;
        set_ch(0, 8'h02, 8'h01, 1'b0, 1'b0);
        set_ch(1, 8'h01, 8'h01, 1'b1, 1'b1);
        #0.5;
        highs = 0;
        for (int k = 0; k < 258; k++) begin
            if (pwm_out[1]) highs++;
            if (k == 256) check(pwm_out[1], 1, "R4 joined pin high at count 256");
            if (k == 257) check(pwm_out[1], 0, "R4 joined pin low at count 257");
            if (pwm_out[0] !== 1'b0) check(pwm_out[0], 0, "R4 even pin low when joined");
            tick();
        end
        check(highs, 257, "R4 16-bit high time");
        check(pwm_out[1], 1, "R4 16-bit wrap back to zero");
    endtask

    task automatic t_shutdown8();
        do_reset();
        sd_enable = 1'b1; safe_lvl = 1'b1;
        set_ch(0, 8, 4, 1'b1, 1'b1);
        set_ch(2, 8, 4, 1'b0, 1'b1);
        set_ch(7, 8, 9, 1'b1, 1'b1);
        #0.5;
        check(pwm_out[7], 0, "R5 top pin low when used as shutdown input");
        adv(2);                       // k = 2
        sd_pin = 1'b1;
        #0.5;
        check(pwm_out[6:0], 7'h7f, "R6 all pins at safe level");
        check(pwm_out[7], 0, "R5 top pin low during shutdown");
        check(sd_flag, 0, "R7 flag not yet set");
        tick();                       // k = 3
        check(sd_flag, 1, "R7 flag set after rise");
        adv(2);                       // k = 5
        sd_pin = 1'b0;
        #0.5;
        for (int k = 5; k < 8; k++) begin
            check(pwm_out[0], 1, "R8 safe level kept before wrap");
            tick();
        end
        check(pwm_out[0], 1, "R8 normal waveform at count zero");
        check(pwm_out[2], 0, "R8 inverted channel released at count zero");
        adv(4);                       // k = 12
        check(pwm_out[0], 0, "R8 normal low phase after release");
        check(sd_flag, 1, "R7 flag sticky after release");
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        #0.5;
        check(sd_flag, 0, "R7 flag cleared by strobe");
        sd_pin = 1'b1; flag_clr = 1'b1;
        tick();
        sd_pin = 1'b0; flag_clr = 1'b0;
        #0.5;
        check(sd_flag, 1, "R7 rise wins over clear");
    endtask

    task automatic t_norestart();
        do_reset();
        sd_enable = 1'b1; safe_lvl = 1'b1; restart_en = 1'b0;
        set_ch(0, 8, 4, 1'b1, 1'b1);
        adv(2);                       // k = 2
        sd_pin = 1'b1;
        adv(3);                       // k = 5
        sd_pin = 1'b0;
        adv(7);                       // k = 12
        check(pwm_out[0], 1, "R9 still safe after a wrap");
        adv(2);                       // k = 14
        check(pwm_out[0], 1, "R9 still safe without restart enable");
        restart_en = 1'b1;
        tick();                       // k = 15
        check(pwm_out[0], 1, "R8 held until next wrap");
        tick();                       // k = 16
        check(pwm_out[0], 1, "R8 released at count zero");
        adv(4);                       // k = 20
        check(pwm_out[0], 0, "R8 low phase after late restart");
    endtask

    task automatic t_ignore();
        do_reset();
        sd_enable = 1'b0;
        set_ch(0, 8, 4, 1'b1, 1'b1);
        set_ch(7, 8, 4, 1'b1, 1'b1);
        tick();                       // k = 1
        sd_pin = 1'b1; safe_lvl = 1'b0;
        #0.5;
        check(pwm_out[0], 1, "R5 shutdown input ignored when disabled");
        check(pwm_out[7], 1, "R5 top channel runs as PWM when not shutdown input");
        tick();
        check(sd_flag, 0, "R5 flag untouched when disabled");
        sd_pin = 1'b0;
    endtask

    task automatic t_cat_sd();
        do_reset();
        sd_enable = 1'b1; safe_lvl = 1'b1;
        pair_cat[0] = 1'b1;
        set_ch(0, 8'h80, 8'h80, 1'b0, 1'b0);
        set_ch(1, 8'h01, 8'h00, 1'b1, 1'b1);
        adv(130);
        sd_pin = 1'b1;
        adv(10);                      // k = 140
        sd_pin = 1'b0;
        adv(116);                     // k = 256, low byte zero
        check(pwm_out[1], 1, "R10 held at low byte zero");
        adv(127);                     // k = 383
        check(pwm_out[1], 1, "R10 held until 16-bit wrap");
        tick();                       // k = 384, count 0
        check(pwm_out[1], 1, "R10 released at 16-bit wrap");
        check(pwm_out[0], 0, "R4 even pin low after release");
        adv(128);                     // count 128
        check(pwm_out[1], 0, "R10 normal low phase after release");
    endtask

    task automatic t_lowpower();
        do_reset();
        sd_enable = 1'b1; safe_lvl = 1'b1;
        set_ch(0, 8, 4, 1'b1, 1'b1);
        adv(2);
        sd_pin = 1'b1;
        adv(3);                       // k = 5
        sd_pin = 1'b0;
        adv(2);                       // k = 7, wrap due next edge
        lp_hold = 1'b1;
        for (int k = 0; k < 10; k++) begin
            tick();
            check(pwm_out[0], 1, "R11 safe level held while frozen");
        end
        lp_hold = 1'b0;
        tick();                       // count 0
        check(pwm_out[0], 1, "R11 released at wrap after thaw");
        adv(4);                       // count 4
        check(pwm_out[0], 0, "R11 counting resumes from frozen value");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_cat();
        t_shutdown8();
        t_norestart();
        t_ignore();
        t_cat_sd();
        t_lowpower();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule